// File: doc/BRIEF.md
# DAC Waveform Overlay Generator

This block sits in one channel of a digital-to-analog data path, between the holding value supplied by the register logic and the code handed to the converter. On every accepted trigger it forms the next output code as the holding value plus a generated waveform sample. The sample is either a triangle ramp or a masked pseudo-random value, and the sum wraps at the code width.

A single 4-bit amplitude code sets both the triangle peak and the noise mask. The wave mode and the amplitude are latched only while the channel is disabled, so they cannot change while the channel runs. When the trigger gate is off, the holding value goes straight to the output on every cycle and the generators stay frozen.

The output is a plain registered code with a one-cycle valid strobe. The block has no back-pressure. A consumer must take the code in the cycle the strobe is high. The code stays on the output until the next update.

Top module: `dac_wave_overlay`

## Requirements
- R1: After reset, out_valid is 0 and out_code is 0.
- R2: Wave mode 0 (off) and 3 (reserved) add nothing to the holding value. Mode 1 selects noise and mode 2 selects triangle.
- R3: Amplitude code k sets the peak or mask to 2^(k+1)-1, so code 0 gives 1 and code 11 gives 4095. Codes 12 to 15 act as code 11.
- R4: In triangle mode the sample starts at 0. It rises by 1 per trigger up to the peak, then falls by 1 per trigger to 0, and repeats. Each trigger uses the current sample, then steps it.
- R5: In noise mode a 12-bit register is seeded with 0xAAA. It shifts left once per trigger, and bit 0 takes the XOR of bits 11, 5, 3 and 0 (polynomial x^12+x^6+x^4+x+1). The sample is the current register value ANDed with the mask, and the register steps after use.
- R6: out_code equals the holding value plus the sample, taken modulo 4096.
- R7: With the channel and its trigger gate enabled, a trigger pulse in cycle t updates out_code and raises out_valid for exactly one cycle, at edge t+1. Without a trigger, out_valid stays 0.
- R8: With the channel enabled and the trigger gate off, out_code follows hold_val one cycle later and out_valid stays high. Trigger pulses are ignored, and both generators keep their state.
- R9: The wave_mode and amp_code inputs are captured only while chan_en is 0. Changes to them while the channel is enabled have no effect.
- R10: While chan_en is 0, out_valid is 0, the triangle restarts at 0 and the noise register is reseeded with 0xAAA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel enable |
| trig_en | input | 1 | Trigger gate: 1 means updates only on triggers |
| trig | input | 1 | One-cycle trigger strobe |
| wave_mode | input | 2 | 0 off, 1 noise, 2 triangle, 3 reserved (off) |
| amp_code | input | 4 | Amplitude / mask code |
| hold_val | input | 12 | Holding value |
| out_code | output | 12 | Output code |
| out_valid | output | 1 | Output update strobe |

## Verification
A wrong triangle counter or a wrong noise register shows as a wrong out_code on the very next trigger. A trigger count that is off by one appears as an offset that the bench compares against a hand-computed sum. Configuration that leaks through while the channel runs would turn a triangle step into a noise value at the next trigger. A missed reseed or counter restart shows on the first trigger after re-enable, and a wrong strobe shows within one cycle of the trigger or of the trigger gate switching off.

// File: rtl/dac_wave_pkg.sv
package dac_wave_pkg;
  typedef enum logic [1:0] {
    WAVE_OFF   = 2'd0,
    WAVE_NOISE = 2'd1,
    WAVE_TRI   = 2'd2,
    WAVE_RSVD  = 2'd3
  } wave_mode_e;
endpackage

// File: rtl/dac_wave_cfg.sv
module dac_wave_cfg
  import dac_wave_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic [1:0]        mode_in,
  input  logic [CODE_W-1:0] code_in,
  output wave_mode_e        mode_q,
  output logic [DATA_W-1:0] mask_q
);
  localparam int MAX_CODE = DATA_W - 1;

  logic [CODE_W-1:0] code_eff;
  logic [DATA_W-1:0] mask_d;

  always_comb begin
    code_eff = (code_in > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code_in;
    mask_d   = {DATA_W{1'b1}} >> (MAX_CODE - int'(code_eff));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= WAVE_OFF;
      mask_q <= DATA_W'(1);
    end else if (!chan_en) begin
      mode_q <= wave_mode_e'(mode_in);
      mask_q <= mask_d;
    end
  end

  // R9: settings frozen while the channel runs
  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(chan_en) |-> ($stable(mode_q) && $stable(mask_q)));
  // R3: mask is a contiguous run of ones from bit 0
  assert_mask_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q[0] && ((mask_q & (mask_q + DATA_W'(1))) == '0));
endmodule

// File: rtl/dac_tri_gen.sv
module dac_tri_gen #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic [DATA_W-1:0] peak,
  output logic [DATA_W-1:0] value
);
  logic falling;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      value   <= '0;
      falling <= 1'b0;
    end else if (step) begin
      if (!falling) begin
        if (value >= peak) begin
          falling <= 1'b1;
          value   <= value - DATA_W'(1);
        end else begin
          value <= value + DATA_W'(1);
        end
      end else begin
        if (value == '0) begin
          falling <= 1'b0;
          value   <= DATA_W'(1);
        end else begin
          value <= value - DATA_W'(1);
        end
      end
    end
  end

  // R4: sample never exceeds the peak
  assert_tri_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    value <= peak);
  // R4: each step moves the sample by exactly one
  assert_tri_unit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear) |=> ((value == $past(value) + DATA_W'(1)) ||
                          (value == $past(value) - DATA_W'(1))));
  // R10: cleared counter sits at zero
  assert_tri_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (value == '0));
endmodule

// File: rtl/dac_noise_gen.sv
module dac_noise_gen #(
  parameter int                DATA_W = 12,
  parameter logic [DATA_W-1:0] SEED   = 12'hAAA,
  parameter logic [DATA_W-1:0] TAPS   = 12'h829
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  output logic [DATA_W-1:0] state
);
  logic feedback;

  always_comb feedback = ^(state & TAPS);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) state <= SEED;
    else if (step)       state <= {state[DATA_W-2:0], feedback};
  end

  // R5: register never locks up at all zeros
  assert_lfsr_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
  // R10: reseed while the channel is off
  assert_lfsr_reseed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (state == SEED));
endmodule

// File: rtl/dac_wave_overlay.sv
module dac_wave_overlay
  import dac_wave_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic              trig_en,
  input  logic              trig,
  input  logic [1:0]        wave_mode,
  input  logic [CODE_W-1:0] amp_code,
  input  logic [DATA_W-1:0] hold_val,
  output logic [DATA_W-1:0] out_code,
  output logic              out_valid
);
  wave_mode_e        mode_q;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] tri_val;
  logic [DATA_W-1:0] lfsr_val;
  logic [DATA_W-1:0] wave_val;
  logic              advance;
  logic              passthru;

  assign advance  = chan_en && trig_en && trig;
  assign passthru = chan_en && !trig_en;

  dac_wave_cfg #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
    .mode_in(wave_mode), .code_in(amp_code),
    .mode_q(mode_q), .mask_q(mask_q)
  );

  dac_tri_gen #(.DATA_W(DATA_W)) u_tri (
    .clk(clk), .rst_n(rst_n), .clear(!chan_en),
    .step(advance && (mode_q == WAVE_TRI)),
    .peak(mask_q), .value(tri_val)
  );

  dac_noise_gen #(.DATA_W(DATA_W)) u_noise (
    .clk(clk), .rst_n(rst_n), .clear(!chan_en),
    .step(advance && (mode_q == WAVE_NOISE)),
    .state(lfsr_val)
  );

  always_comb begin
    case (mode_q)
      WAVE_TRI:   wave_val = tri_val;
      WAVE_NOISE: wave_val = lfsr_val & mask_q;
      default:    wave_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_code  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= advance || passthru;
      if (advance)       out_code <= hold_val + wave_val;
      else if (passthru) out_code <= hold_val;
    end
  end

  // R10: no strobe while the channel is off
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> !out_valid);
  // R7: gated mode stays silent without a trigger
  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && trig_en && !trig) |=> (!out_valid && $stable(out_code)));
  // R8: ungated mode forwards the holding value
  assert_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
    passthru |=> (out_valid && (out_code == $past(hold_val))));
endmodule

// File: tb/dac_wave_overlay_bench.sv
module dac_wave_overlay_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chan_en = 1'b0;
  logic        trig_en = 1'b0;
  logic        trig = 1'b0;
  logic [1:0]  wave_mode = 2'd0;
  logic [3:0]  amp_code = 4'd0;
  logic [11:0] hold_val = 12'd0;
  logic [11:0] out_code;
  logic        out_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dac_wave_overlay u_dac_wave_overlay (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .trig_en(trig_en),
    .trig(trig), .wave_mode(wave_mode), .amp_code(amp_code),
    .hold_val(hold_val), .out_code(out_code), .out_valid(out_valid)
  );

  // {mode[37:36], amp[35:32], hold[31:20], triggers[19:12], expected[11:0]}
  localparam logic [37:0] VEC [8] = '{
    {2'd2, 4'd1,  12'd100,  8'd5,   12'd102},  // R4 triangle peak 3
    {2'd2, 4'd0,  12'd4095, 8'd2,   12'd0},    // R6 wrap, R3 code 0
    {2'd1, 4'd3,  12'd16,   8'd1,   12'd26},   // R5 seed masked to 4 bits
    {2'd1, 4'd15, 12'd0,    8'd2,   12'h555},  // R5 one shift, R3 clamp
    {2'd0, 4'd5,  12'd1234, 8'd3,   12'd1234}, // R2 off
    {2'd3, 4'd9,  12'd77,   8'd2,   12'd77},   // R2 reserved
    {2'd2, 4'd11, 12'd4000, 8'd200, 12'd103},  // R4 long ramp, R6 wrap
    {2'd1, 4'd7,  12'd4090, 8'd1,   12'd164}   // R6 noise wrap
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic configure(input logic [1:0] m, input logic [3:0] a);
    @(negedge clk);
    chan_en = 1'b0; wave_mode = m; amp_code = a;
    @(negedge clk);
    chan_en = 1'b1; trig_en = 1'b1;
  endtask

  task automatic pulse();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_valid", out_valid, 0);
    check("R1 out_code", out_code, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      configure(VEC[i][37:36], VEC[i][35:32]);
      hold_val = VEC[i][31:20];
      for (int n = 0; n < int'(VEC[i][19:12]); n++) pulse();
      check($sformatf("R6 vector %0d code", i), out_code, int'(VEC[i][11:0]));
      check($sformatf("R7 vector %0d strobe", i), out_valid, 1);
    end

    // R7: strobe lasts one cycle
    @(negedge clk);
    check("R7 strobe drops", out_valid, 0);

    // R8: pass-through and frozen triangle
    configure(2'd2, 4'd1);
    hold_val = 12'd50;
    pulse(); pulse();
    check("R4 second sample", out_code, 51);
    trig_en = 1'b0;
    @(negedge clk);
    check("R8 pass code", out_code, 50);
    check("R8 pass strobe", out_valid, 1);
    trig = 1'b1; hold_val = 12'd60;
    @(negedge clk);
    trig = 1'b0;
    check("R8 trigger ignored", out_code, 60);
    trig_en = 1'b1; hold_val = 12'd50;
    @(negedge clk);
    check("R7 no trigger no strobe", out_valid, 0);
    pulse();
    check("R8 generator frozen", out_code, 52);

    // R9: config changes while enabled ignored
    wave_mode = 2'd1; amp_code = 4'd11;
    pulse();
    check("R9 still triangle", out_code, 53);
    pulse();
    check("R4 falling", out_code, 52);

    // R10: disable, noise captured, reseed
    chan_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R10 quiet when off", out_valid, 0);
    chan_en = 1'b1;
    pulse();
    check("R10 seed sample", out_code, 50 + 12'hAAA);
    pulse();
    check("R5 stepped sample", out_code, 50 + 12'h555);
    chan_en = 1'b0;
    @(negedge clk);
    chan_en = 1'b1;
    pulse();
    check("R10 reseeded", out_code, 50 + 12'hAAA);

    // R10: triangle restart
    configure(2'd2, 4'd2);
    hold_val = 12'd10;
    pulse(); pulse(); pulse();
    check("R4 third sample", out_code, 12);
    configure(2'd2, 4'd2);
    pulse();
    check("R10 triangle restart", out_code, 10);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule